// File: doc/BRIEF.md
# Ping-Pong Audio Packet Buffer Controller

This block moves one packet of 8-bit PCM audio per frame in each direction between a packet endpoint engine and a codec sample port. It holds two packet buffers per direction and a buffer phase bit. During a frame the endpoint side owns the buffers selected by the phase bit: it writes received playback bytes into one and reads captured bytes from the other. The codec side owns the opposite pair, playing one out and recording into the other. At every frame tick the roles swap.

The endpoint engine queues packets against one of two descriptor slots, even and odd, and the block reports which slot it is waiting on. The descriptor parity is kept apart from the buffer phase. A frame that ends without a complete packet has its buffer overwritten with silence (0xFF), and a saturating miss counter goes up by one. The descriptor parity is then held, so the next frame waits on the same slot. The buffer phase still swaps. A packet that arrives late is therefore played one frame later, in its proper place, and never ahead of an earlier packet.

Top module: `ppb_ctrl`

## Requirements
- R1: After reset, desc_phase, buf_phase and miss_count are 0 and ep_arm is low. Every buffer byte holds 0xFF, so pcm_rd and in_data both read 0xFF.
- R2: A frame tick occurs every TICK_CYCLES clock cycles. ep_arm is high for exactly one cycle, the cycle after each tick. buf_phase toggles on every tick and on no other cycle.
- R3: Bytes presented with out_valid during a frame are stored in arrival order. Once PKT_BYTES of them have arrived, the packet is complete. In the next frame, successive pcm_strobe pulses return those bytes on pcm_rd in the same order.
- R4: out_valid bytes beyond the first PKT_BYTES of a frame are ignored and do not change the packet played in the next frame.
- R5: A frame that ends with fewer than PKT_BYTES bytes received, including zero, makes every pcm_rd byte of the next frame 0xFF.
- R6: desc_phase toggles at a tick that closes a complete frame and holds at a tick that closes an incomplete frame. It never changes between ticks.
- R7: miss_count increments by one at every tick that closes an incomplete frame and saturates at all ones. It is otherwise unchanged.
- R8: Bytes written with pcm_wr on successive pcm_strobe pulses in one frame are returned in the same order on in_data, advancing on in_rd, in the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| out_valid | input | 1 | Playback byte strobe from the endpoint engine |
| out_data | input | 8 | Playback byte from the endpoint engine |
| in_rd | input | 1 | Endpoint engine reads one captured byte; advances the read index |
| in_data | output | 8 | Captured byte at the current read index |
| pcm_strobe | input | 1 | Codec sample strobe; advances both codec indices |
| pcm_wr | input | 8 | Captured sample from the codec, stored on pcm_strobe |
| pcm_rd | output | 8 | Playback sample toward the codec at the current index |
| ep_arm | output | 1 | One-cycle pulse after each frame tick |
| desc_phase | output | 1 | Descriptor slot awaited this frame (0 even, 1 odd) |
| buf_phase | output | 1 | Buffer pair owned by the endpoint side this frame |
| miss_count | output | MISS_W | Saturating count of incomplete frames |

## Verification
The bench runs 28 consecutive frames. Each frame carries one of four playback patterns: a full packet, no bytes, a truncated packet of five bytes, or a packet followed by two surplus bytes. The full and surplus frames show whether completion detection and the byte limit work. The empty and truncated frames show whether silence is substituted and whether the descriptor slot is retried rather than advanced. A run of three empty frames, with misses well beyond the small counter's range, checks saturation. A distinct capture ramp in every frame shows whether the two directions use opposite buffers and whether they swap at each tick.

// File: rtl/ppb_pkg.sv
package ppb_pkg;
  typedef logic [7:0] byte_t;
  localparam byte_t SILENCE = 8'hFF;
endpackage

// File: rtl/ppb_tick.sv
// Free-running frame tick: one pulse every TICK_CYCLES clocks.
module ppb_tick #(
  parameter int unsigned TICK_CYCLES = 12000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int unsigned CW = $clog2(TICK_CYCLES);
  localparam logic [CW-1:0] LAST = CW'(TICK_CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = (cnt_q == LAST);
    cnt_d = tick ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/ppb_cursor.sv
// Wrapping byte index, cleared at every frame tick.
module ppb_cursor #(
  parameter  int unsigned DEPTH = 8,
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          step,
  output logic [AW-1:0] idx
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [AW-1:0] idx_q, idx_d;
  logic          en;

  always_comb begin
    en    = clr | step;
    idx_d = idx_q;
    if (clr)                idx_d = '0;
    else if (idx_q == LAST) idx_d = '0;
    else                    idx_d = idx_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  idx_q <= '0;
    else if (en) idx_q <= idx_d;
  end

  assign idx = idx_q;
endmodule

// File: rtl/ppb_seq.sv
// Frame sequencer: completion check, silence request, descriptor retry,
// buffer swap and miss counting.
module ppb_seq #(
  parameter  int unsigned PKT_BYTES = 8,
  parameter  int unsigned MISS_W    = 8,
  localparam int unsigned AW        = $clog2(PKT_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              out_valid,
  output logic              wr_en,
  output logic [AW-1:0]     wr_idx,
  output logic              fill_en,
  output logic              arm,
  output logic              desc,
  output logic              bsel,
  output logic [MISS_W-1:0] miss
);
  localparam int unsigned CW = $clog2(PKT_BYTES + 1);
  localparam logic [CW-1:0] FULL = CW'(PKT_BYTES);
  localparam logic [MISS_W-1:0] MISS_MAX = '1;

  logic [CW-1:0]     wptr_q, wptr_d;
  logic              desc_q, desc_d;
  logic              bsel_q, bsel_d;
  logic [MISS_W-1:0] miss_q, miss_d;
  logic              arm_q;
  logic              done;

  always_comb begin
    done    = (wptr_q == FULL);
    wr_en   = out_valid && !done && !tick;
    wr_idx  = wptr_q[AW-1:0];
    fill_en = tick && !done;

    wptr_d = wptr_q;
    desc_d = desc_q;
    bsel_d = bsel_q;
    miss_d = miss_q;
    if (tick) begin
      wptr_d = '0;
      bsel_d = ~bsel_q;
      if (done)                  desc_d = ~desc_q;
      else if (miss_q != MISS_MAX) miss_d = miss_q + 1'b1;
    end else if (wr_en) begin
      wptr_d = wptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      desc_q <= 1'b0;
      bsel_q <= 1'b0;
      miss_q <= '0;
      arm_q  <= 1'b0;
    end else begin
      arm_q <= tick;
      if (tick || wr_en) wptr_q <= wptr_d;
      if (tick) begin
        desc_q <= desc_d;
        bsel_q <= bsel_d;
        miss_q <= miss_d;
      end
    end
  end

  assign arm  = arm_q;
  assign desc = desc_q;
  assign bsel = bsel_q;
  assign miss = miss_q;
endmodule

// File: rtl/ppb_bank.sv
// Two buffer pairs; pair usb_sel belongs to the endpoint side, the other
// pair to the codec side.
module ppb_bank import ppb_pkg::*; #(
  parameter  int unsigned PKT_BYTES = 8,
  localparam int unsigned AW        = $clog2(PKT_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          usb_sel,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_idx,
  input  byte_t         wr_data,
  input  logic          fill_en,
  input  logic          cap_en,
  input  logic [AW-1:0] cap_idx,
  input  byte_t         cap_data,
  input  logic [AW-1:0] play_idx,
  input  logic [AW-1:0] tx_idx,
  output byte_t         play_data,
  output byte_t         tx_data
);
  logic [1:0][7:0] ph_play;
  logic [1:0][7:0] ph_tx;

  for (genvar p = 0; p < 2; p++) begin : g_ph
    localparam logic PH = (p == 1);

    byte_t out_q [PKT_BYTES];
    byte_t out_d [PKT_BYTES];
    byte_t in_q  [PKT_BYTES];
    byte_t in_d  [PKT_BYTES];
    logic  usb_own;
    logic  out_en, in_en;

    assign usb_own = (usb_sel == PH);

    always_comb begin
      out_d  = out_q;
      in_d   = in_q;
      out_en = usb_own && (fill_en || wr_en);
      in_en  = !usb_own && cap_en;
      if (usb_own && fill_en) begin
        for (int i = 0; i < PKT_BYTES; i++) out_d[i] = SILENCE;
      end else if (usb_own && wr_en) begin
        out_d[wr_idx] = wr_data;
      end
      if (in_en) in_d[cap_idx] = cap_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int i = 0; i < PKT_BYTES; i++) begin
          out_q[i] <= SILENCE;
          in_q[i]  <= SILENCE;
        end
      end else begin
        if (out_en) out_q <= out_d;
        if (in_en)  in_q  <= in_d;
      end
    end

    assign ph_play[p] = out_q[play_idx];
    assign ph_tx[p]   = in_q[tx_idx];
  end

  assign play_data = ph_play[~usb_sel];
  assign tx_data   = ph_tx[usb_sel];
endmodule

// File: rtl/ppb_ctrl.sv
module ppb_ctrl import ppb_pkg::*; #(
  parameter int unsigned PKT_BYTES   = 8,
  parameter int unsigned TICK_CYCLES = 12000,
  parameter int unsigned MISS_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              out_valid,
  input  logic [7:0]        out_data,
  input  logic              in_rd,
  output logic [7:0]        in_data,
  input  logic              pcm_strobe,
  input  logic [7:0]        pcm_wr,
  output logic [7:0]        pcm_rd,
  output logic              ep_arm,
  output logic              desc_phase,
  output logic              buf_phase,
  output logic [MISS_W-1:0] miss_count
);
  localparam int unsigned AW = $clog2(PKT_BYTES);

  logic [1:0]    rst_sync_q;
  logic          core_rst_n;
  logic          tick;
  logic          wr_en, fill_en, bsel;
  logic [AW-1:0] wr_idx, pcm_idx, tx_idx;

  // Reset asserts at once and releases two edges later.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  ppb_tick #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
    .clk(clk), .rst_n(core_rst_n), .tick(tick)
  );

  ppb_seq #(.PKT_BYTES(PKT_BYTES), .MISS_W(MISS_W)) u_seq (
    .clk(clk), .rst_n(core_rst_n), .tick(tick), .out_valid(out_valid),
    .wr_en(wr_en), .wr_idx(wr_idx), .fill_en(fill_en), .arm(ep_arm),
    .desc(desc_phase), .bsel(bsel), .miss(miss_count)
  );

  ppb_cursor #(.DEPTH(PKT_BYTES)) u_pcm_cur (
    .clk(clk), .rst_n(core_rst_n), .clr(tick), .step(pcm_strobe), .idx(pcm_idx)
  );

  ppb_cursor #(.DEPTH(PKT_BYTES)) u_tx_cur (
    .clk(clk), .rst_n(core_rst_n), .clr(tick), .step(in_rd), .idx(tx_idx)
  );

  ppb_bank #(.PKT_BYTES(PKT_BYTES)) u_bank (
    .clk(clk), .rst_n(core_rst_n), .usb_sel(bsel),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(out_data), .fill_en(fill_en),
    .cap_en(pcm_strobe && !tick), .cap_idx(pcm_idx), .cap_data(pcm_wr),
    .play_idx(pcm_idx), .tx_idx(tx_idx),
    .play_data(pcm_rd), .tx_data(in_data)
  );

  assign buf_phase = bsel;
endmodule

// File: rtl/ppb_chk.sv
module ppb_chk #(
  parameter int unsigned MISS_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ep_arm,
  input logic              desc_phase,
  input logic              buf_phase,
  input logic [MISS_W-1:0] miss_count
);
  localparam logic [MISS_W-1:0] SAT = '1;

  p_arm_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ep_arm |=> !ep_arm);

  p_buf_toggle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ep_arm |-> (buf_phase != $past(buf_phase)));

  p_buf_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ep_arm |-> $stable(buf_phase));

  p_desc_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ep_arm |-> $stable(desc_phase));

  p_miss_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ep_arm && (desc_phase == $past(desc_phase))) |->
      ((miss_count == $past(miss_count) + 1'b1) ||
       ((miss_count == SAT) && ($past(miss_count) == SAT))));

  p_miss_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ep_arm && (desc_phase != $past(desc_phase))) |->
      (miss_count == $past(miss_count)));

  p_miss_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !ep_arm |-> $stable(miss_count));
endmodule

bind ppb_ctrl ppb_chk #(.MISS_W(MISS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ep_arm(ep_arm), .desc_phase(desc_phase),
  .buf_phase(buf_phase), .miss_count(miss_count)
);

// File: tb/tb_ppb_ctrl.sv
module tb_ppb_ctrl;
  localparam int PKT  = 8;
  localparam int TICK = 40;
  localparam int MW   = 3;
  localparam int NW   = 28;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n, out_valid, in_rd, pcm_strobe;
  logic [7:0]    out_data, pcm_wr, in_data, pcm_rd;
  logic          ep_arm, desc_phase, buf_phase;
  logic [MW-1:0] miss_count;

  ppb_ctrl #(.PKT_BYTES(PKT), .TICK_CYCLES(TICK), .MISS_W(MW)) dut (
    .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_data(out_data),
    .in_rd(in_rd), .in_data(in_data), .pcm_strobe(pcm_strobe), .pcm_wr(pcm_wr),
    .pcm_rd(pcm_rd), .ep_arm(ep_arm), .desc_phase(desc_phase),
    .buf_phase(buf_phase), .miss_count(miss_count)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  always @(posedge clk) cyc++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // 0 full packet, 1 nothing, 2 truncated (5 bytes), 3 packet plus 2 surplus bytes
  function automatic int mode_of(input int k);
    if (k >= 14 && k <= 16) return 1;
    case (k % 7)
      2, 6:    return 1;
      3:       return 2;
      4:       return 3;
      default: return 0;
    endcase
  endfunction

  initial begin
    #(200000 * 10);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] exp_play [PKT];
    logic [7:0] next_play[PKT];
    logic [7:0] exp_in   [PKT];
    logic [7:0] next_in  [PKT];
    logic       exp_desc, exp_buf;
    int         exp_miss, seq, last_arm, m, nb;

    rst_n = 1'b0; out_valid = 1'b0; out_data = '0; in_rd = 1'b0;
    pcm_strobe = 1'b0; pcm_wr = '0;
    for (int j = 0; j < PKT; j++) begin exp_play[j] = 8'hFF; exp_in[j] = 8'hFF; end
    exp_desc = 1'b0; exp_buf = 1'b0; exp_miss = 0; seq = 1; last_arm = 0;

    repeat (3) @(negedge clk);
    // R1: reset state
    chk(desc_phase == 1'b0, "R1 desc_phase", desc_phase, 0);
    chk(buf_phase == 1'b0, "R1 buf_phase", buf_phase, 0);
    chk(miss_count == '0, "R1 miss_count", miss_count, 0);
    chk(ep_arm == 1'b0, "R1 ep_arm", ep_arm, 0);
    chk(pcm_rd == 8'hFF, "R1 pcm_rd", pcm_rd, 8'hFF);
    chk(in_data == 8'hFF, "R1 in_data", in_data, 8'hFF);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    for (int k = 0; k < NW; k++) begin
      if (k > 0) begin
        do @(negedge clk); while (!ep_arm);
        if (k > 1) chk(cyc - last_arm == TICK, "R2 tick spacing", cyc - last_arm, TICK);
        last_arm = cyc;
      end
      chk(buf_phase == exp_buf, "R2 buf_phase", buf_phase, exp_buf);
      chk(desc_phase == exp_desc, "R6 desc_phase", desc_phase, exp_desc);
      chk(int'(miss_count) == exp_miss, "R7 miss_count", miss_count, exp_miss);

      m  = mode_of(k);
      nb = (m == 0) ? PKT : (m == 2) ? 5 : (m == 3) ? PKT + 2 : 0;
      for (int j = 0; j < PKT + 2; j++) begin
        out_valid = (j < nb);
        out_data  = (j < PKT) ? 8'(seq * 8 + j) : 8'h5A;
        if (j < PKT) begin
          // R3 / R4 / R5: playback of the previous frame's packet or silence
          chk(pcm_rd == exp_play[j], (exp_play[j] == 8'hFF) ? "R5 silence" : "R3 playback",
              pcm_rd, exp_play[j]);
          // R8: capture of the previous frame comes back on in_data
          chk(in_data == exp_in[j], "R8 capture return", in_data, exp_in[j]);
          pcm_strobe = 1'b1;
          in_rd      = 1'b1;
          pcm_wr     = 8'(8'h80 + k * 8 + j);
          next_in[j] = pcm_wr;
        end else begin
          pcm_strobe = 1'b0;
          in_rd      = 1'b0;
        end
        @(negedge clk);
      end
      out_valid = 1'b0; pcm_strobe = 1'b0; in_rd = 1'b0;

      if (m == 0 || m == 3) begin
        for (int j = 0; j < PKT; j++) next_play[j] = 8'(seq * 8 + j);
        exp_desc = ~exp_desc;
      end else begin
        for (int j = 0; j < PKT; j++) next_play[j] = 8'hFF;
        if (exp_miss < (1 << MW) - 1) exp_miss++;
      end
      if (m != 1) seq++;
      exp_play = next_play;
      exp_in   = next_in;
      exp_buf  = ~exp_buf;
    end

    // Closing frame: effect of the last tick
    do @(negedge clk); while (!ep_arm);
    chk(desc_phase == exp_desc, "R6 final desc_phase", desc_phase, exp_desc);
    chk(int'(miss_count) == exp_miss, "R7 final saturation", miss_count, exp_miss);
    for (int j = 0; j < PKT; j++) begin
      chk(pcm_rd == exp_play[j], "R5 final playback", pcm_rd, exp_play[j]);
      pcm_strobe = 1'b1;
      @(negedge clk);
    end
    pcm_strobe = 1'b0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule